// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block watches a small bank of general-purpose input pins and turns their transitions into one interrupt line for a parent interrupt controller. Every pin passes through a two-flop synchronizer, and an edge detector compares the current synchronized sample with the previous one. Each rising and each falling transition is held in its own sticky latch. Both latches record events whatever the pin's trigger setting is.

Software configures each pin with a 2-bit trigger code. The code selects which latch, the falling one or the rising one, shows through the visible status register and can raise the interrupt. The hardware cannot trigger on both edges at once. To get both-edge behaviour, software reads the current pin level and programs the opposite polarity after each event. Because of this, a write-one acknowledge clears both latches of a pin. Any edge that arrives after the acknowledge is latched again, so no event is lost when the polarity is flipped.

Access is through a synchronous register port. Read data is registered.

Top module: `gpio_edge_irq`

## Requirements
- R1: The trigger register (address 0) holds a 2-bit field for input i at bits [2i+1:2i]. Code 2'b01 selects the falling latch, code 2'b10 selects the rising latch, and code 2'b00 selects nothing. The register reads back what was written.
- R2: Trigger code 2'b11 behaves exactly like 2'b00: the input's visible status bit reads 0.
- R3: Rising and falling events are latched for every input under any trigger code. Switching the trigger to a polarity whose latch is already set makes the status bit, and the interrupt, appear without any new edge.
- R4: `irq_out` is a registered OR of all visible status bits. It rises one clock after a visible bit becomes set and falls one clock after all visible bits clear.
- R5: Writing 1 to bit i of the status register (address 1) clears both of input i's latches, whatever trigger is selected.
- R6: Writing 0 to a status bit leaves that input's latches unchanged.
- R7: An edge detected in the same cycle as a clear write for that input wins, and the latch stays set.
- R8: A pin change reaches the edge latch three clocks after it is sampled (two synchronizer stages plus the previous-sample stage). The level register (address 2) returns the synchronized pin levels in bits [N-1:0].
- R9: Synchronous reset clears the trigger register, every latch and `irq_out`.
- R10: A read strobed in one cycle presents its data on `bus_rdata` after the next rising clock edge. The status register reads back the visible bits in [N-1:0], and unused bits and addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (2) | Register address |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Registered read data |
| pins_in | input | NUM_IN (4) | Asynchronous input pins |
| irq_out | output | 1 | Interrupt request to the parent controller |

## Verification
The bench uses the default parameters: four inputs, an 8-bit data path and two synchronizer stages. With these values the four trigger fields fill the whole trigger register, so every one of the four codes can sit in a different field at the same time, and one status write can hit any mix of inputs. The two-stage synchronizer makes the edge-to-latch delay short and fixed. That lets the bench place a clear write in exactly the cycle where an edge reaches the latch. It also lets the bench check the interrupt cycle by cycle.

// File: rtl/gei_pkg.sv
package gei_pkg;

  typedef enum logic [1:0] {
    TRIG_NONE = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_BAD  = 2'b11
  } trig_e;

  localparam logic [1:0] ADDR_TRIG  = 2'd0;
  localparam logic [1:0] ADDR_STAT  = 2'd1;
  localparam logic [1:0] ADDR_LEVEL = 2'd2;

endpackage

// File: rtl/gei_sync_edge.sv
module gei_sync_edge #(
  parameter int NUM_IN      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] pins_in,
  output logic [NUM_IN-1:0] level,
  output logic [NUM_IN-1:0] rise_ev,
  output logic [NUM_IN-1:0] fall_ev
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_IN-1:0] chain [SYNC_STAGES];
  logic [NUM_IN-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= pins_in;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= chain[LAST];
  end

  assign level   = chain[LAST];
  assign rise_ev = chain[LAST] & ~prev_q;
  assign fall_ev = ~chain[LAST] & prev_q;

endmodule

// File: rtl/gei_edge_latch.sv
module gei_edge_latch #(
  parameter int NUM_IN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] rise_ev,
  input  logic [NUM_IN-1:0] fall_ev,
  input  logic [NUM_IN-1:0] clr,
  output logic [NUM_IN-1:0] rise_q,
  output logic [NUM_IN-1:0] fall_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      rise_q <= rise_ev | (rise_q & ~clr);
      fall_q <= fall_ev | (fall_q & ~clr);
    end
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_chk
    p_clear_rise_r5: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !rise_ev[i]) |=> !rise_q[i]);
    p_clear_fall_r5: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !fall_ev[i]) |=> !fall_q[i]);
    p_edge_wins_r7: assert property (@(posedge clk) disable iff (rst)
      (rise_ev[i] && clr[i]) |=> rise_q[i]);
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (!clr[i] && rise_q[i]) |=> rise_q[i]);
  end

endmodule

// File: rtl/gei_trig_select.sv
module gei_trig_select
  import gei_pkg::*;
#(
  parameter int NUM_IN = 4
) (
  input  logic [2*NUM_IN-1:0] trig_cfg,
  input  logic [NUM_IN-1:0]   rise_q,
  input  logic [NUM_IN-1:0]   fall_q,
  output logic [NUM_IN-1:0]   vis
);

  for (genvar i = 0; i < NUM_IN; i++) begin : g_sel
    trig_e code;
    assign code = trig_e'(trig_cfg[2*i +: 2]);
    always_comb begin
      unique case (code)
        TRIG_FALL: vis[i] = fall_q[i];
        TRIG_RISE: vis[i] = rise_q[i];
        default:   vis[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gei_pkg::*;
#(
  parameter int NUM_IN      = 4,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_IN-1:0] pins_in,
  output logic              irq_out
);

  localparam int CFG_W = 2 * NUM_IN;

  logic [CFG_W-1:0]  trig_q;
  logic [NUM_IN-1:0] level, rise_ev, fall_ev, rise_q, fall_q, vis, clr;
  logic [DATA_W-1:0] rd_next;
  logic              irq_q;

  gei_sync_edge #(.NUM_IN(NUM_IN), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pins_in(pins_in),
    .level(level), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  gei_edge_latch #(.NUM_IN(NUM_IN)) u_latch (
    .clk(clk), .rst(rst), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .clr(clr), .rise_q(rise_q), .fall_q(fall_q)
  );

  gei_trig_select #(.NUM_IN(NUM_IN)) u_sel (
    .trig_cfg(trig_q), .rise_q(rise_q), .fall_q(fall_q), .vis(vis)
  );

  assign clr = (bus_wr && bus_addr == ADDR_W'(ADDR_STAT)) ? bus_wdata[NUM_IN-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst)
      trig_q <= '0;
    else if (bus_wr && bus_addr == ADDR_W'(ADDR_TRIG))
      trig_q <= bus_wdata[CFG_W-1:0];
  end

  always_comb begin
    rd_next = '0;
    unique case (bus_addr)
      ADDR_W'(ADDR_TRIG):  rd_next[CFG_W-1:0]  = trig_q;
      ADDR_W'(ADDR_STAT):  rd_next[NUM_IN-1:0] = vis;
      ADDR_W'(ADDR_LEVEL): rd_next[NUM_IN-1:0] = level;
      default:             rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |vis;
  end

  assign irq_out = irq_q;

  p_irq_rise_r4: assert property (@(posedge clk) disable iff (rst)
    (|vis) |=> irq_out);
  p_irq_fall_r4: assert property (@(posedge clk) disable iff (rst)
    !(|vis) |=> !irq_out);
  p_trig_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(trig_q));

endmodule

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] pins_in = '0;
  logic       irq_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  gpio_edge_irq u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pins_in(pins_in), .irq_out(irq_out)
  );

  // {pins before, pins after, trigger register, expected status}
  localparam logic [19:0] VEC [0:6] = '{
    20'h0FAAF, 20'h0F550, 20'hF055F, 20'h05FF0,
    20'hA5C63, 20'h3C5A0, 20'h3CA5F
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    check("R9 irq after reset", {7'd0, irq_out}, 8'h00);
    rd(2'd0, d); check("R9 trigger after reset", d, 8'h00);
    rd(2'd1, d); check("R10 status after reset", d, 8'h00);

    // R1 readback
    wr(2'd0, 8'hC6); rd(2'd0, d); check("R1 trigger readback", d, 8'hC6);
    rd(2'd3, d); check("R10 unused address", d, 8'h00);

    // Vector table: R1 R2 R4
    for (int v = 0; v < 7; v++) begin
      pins_in = VEC[v][19:16];
      settle();
      wr(2'd0, VEC[v][11:4]);
      wr(2'd1, 8'h0F);
      pins_in = VEC[v][15:12];
      settle();
      rd(2'd1, d);
      check($sformatf("R1/R2 vector %0d status", v), d, {4'd0, VEC[v][3:0]});
      check($sformatf("R4 vector %0d irq", v), {7'd0, irq_out},
            {7'd0, VEC[v][3:0] != 4'd0});
    end

    // R6 writing zeros changes nothing (status left at F by last vector)
    wr(2'd1, 8'h00);
    rd(2'd1, d); check("R6 zero write keeps status", d, 8'h0F);

    // R8 level register
    pins_in = 4'b1001; settle();
    rd(2'd2, d); check("R8 level register", d, 8'h09);

    // R3 hidden latch revealed by trigger switch
    pins_in = 4'b0000; settle();
    wr(2'd0, 8'h00); wr(2'd1, 8'h0F);
    pins_in = 4'b0010; settle();
    rd(2'd1, d); check("R3 none hides event", d, 8'h00);
    wr(2'd0, 8'h08);
    @(negedge clk);
    check("R3 irq at once after switch", {7'd0, irq_out}, 8'h01);
    rd(2'd1, d); check("R3 status after switch", d, 8'h02);

    // R5 clear both latches regardless of trigger
    pins_in = 4'b0000; settle();          // input1 now has rise and fall latched
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h04);                      // falling on input1
    rd(2'd1, d); check("R5 falling latch cleared", d, 8'h00);
    wr(2'd0, 8'h08);
    rd(2'd1, d); check("R5 rising latch cleared", d, 8'h00);
    @(negedge clk);
    check("R4 irq low after clear", {7'd0, irq_out}, 8'h00);

    // R8/R4 latency: rising on input2
    wr(2'd0, 8'h20);
    @(negedge clk); pins_in = 4'b0100;
    repeat (3) @(negedge clk);
    check("R8 no irq three clocks after pin", {7'd0, irq_out}, 8'h00);
    @(negedge clk);
    check("R4 irq four clocks after pin", {7'd0, irq_out}, 8'h01);

    // R7 edge coinciding with clear wins
    pins_in = 4'b0000; settle();
    wr(2'd0, 8'h02);                      // rising on input0
    wr(2'd1, 8'h0F);
    @(negedge clk); pins_in = 4'b0001;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h01;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(2'd1, d); check("R7 edge beats clear", d, 8'h01);

    // R9 reset mid-run clears config and latches
    pins_in = 4'b0000; settle();
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    check("R9 irq after mid reset", {7'd0, irq_out}, 8'h00);
    rd(2'd0, d); check("R9 trigger cleared", d, 8'h00);
    wr(2'd0, 8'hAA); rd(2'd1, d); check("R9 rise latches cleared", d, 8'h00);
    wr(2'd0, 8'h55); rd(2'd1, d); check("R9 fall latches cleared", d, 8'h00);

    summary();
  end

endmodule